// File: doc/BRIEF.md
# Byte-Lane Write Synchronous SRAM Core

This block is a clocked single-port memory with a 32-bit word and a depth set by a parameter. Its address comes from an external burst sequencer. Each clock edge samples one cycle's worth of control: a chip select, a sleep request, a whole-word write override, a lane-write qualifier and four per-lane selects. From these the block decides whether the cycle writes some byte lanes, reads the word, or does nothing.

Read data is registered and presented after the edge that sampled the read. The three-state output pad is modelled by a drive flag, `rd_drive`, together with a data bus that is held at zero whenever the flag is low. Output enable and sleep gate the drive flag directly, without waiting for a clock edge.

A three-state machine tracks what the last sampled cycle was. The states are `ST_HIZ` (nothing selected, sleep, or reset), `ST_READ` (read data is held) and `ST_WRITE` (the bus is an input). On every edge there is one transition, picked by the sampled cycle kind:
- **take_none** goes to `ST_HIZ`.
- **take_read** goes to `ST_READ`.
- **take_write** goes to `ST_WRITE`.

Any state may take any of these transitions. Reset enters `ST_HIZ`.

Top module: `sram_bw_core`

## Requirements
- R1: A cycle is active when `sel_n` is 0 and `sleep` is 0. In an active cycle with `wr_all_n` = 0, all four lanes of `addr` are written from `din`, whatever `byte_wr_n` and `lane_sel_n` hold.
- R2: In an active cycle with `wr_all_n` = 1 and `byte_wr_n` = 0, lane i is written exactly when `lane_sel_n[i]` = 0. Lane i is bits 8i+7:8i, so `lane_sel_n[0]` maps to bits 7:0 and `lane_sel_n[3]` maps to bits 31:24. Unselected lanes keep their contents, and any combination of lanes may be written.
- R3: An active cycle is a read in two cases: `wr_all_n` = 1 and `byte_wr_n` = 1, or `byte_wr_n` = 0 with `lane_sel_n` = 4'b1111. A read changes no memory contents.
- R4: The word read at an edge appears on `rd_data` with `rd_drive` = 1 after that edge, provided `out_en_n` = 0 and `sleep` = 0. A read at the edge after a write to the same address returns the new contents.
- R5: While `out_en_n` = 1, `rd_drive` is 0. This gating acts at once, without a clock edge, and the held read data returns when `out_en_n` falls again.
- R6: After an edge that samples a write, `rd_drive` is 0 for the following cycle.
- R7: While `sleep` = 1, `rd_drive` is 0 immediately. A cycle sampled with `sleep` = 1 writes nothing.
- R8: A cycle sampled with `sel_n` = 1 writes nothing, and `rd_drive` is 0 after that edge.
- R9: While `rst_n` = 0, and afterwards until a read is presented, `rd_drive` is 0. `rd_data` is all zero whenever `rd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Sleep request, active high |
| wr_all_n | input | 1 | Whole-word write override, active low |
| byte_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address from the burst sequencer |
| din | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the output pads would drive |

## Verification
The registered read path and the asynchronous output gating can act in the same cycle. While a read result is held in `ST_READ`, the bench raises `out_en_n` or `sleep` between clock edges. It then checks that `rd_drive` drops at once and that the same word returns when the signal is released, with no new edge. A write at the edge right after a read is also driven through the scoreboard. There the sampled write must force the following cycle to high impedance, and the next read must return the merged word held in a shadow memory.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

    typedef enum logic [1:0] {
        ST_HIZ   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } out_state_t;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
    import sram_pkg::*;
(
    input  logic             sel_n,
    input  logic             sleep,
    input  logic             wr_all_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cyc_kind_t        kind,
    output logic [LANES-1:0] lane_we
);
    logic             active;
    logic [LANES-1:0] lanes_req;

    always_comb begin
        active = !sel_n && !sleep;
        if (!wr_all_n) begin
            lanes_req = '1;
        end else if (!byte_wr_n) begin
            lanes_req = ~lane_sel_n;
        end else begin
            lanes_req = '0;
        end

        if (!active) begin
            kind = CYC_NONE;
        end else if (|lanes_req) begin
            kind = CYC_WRITE;
        end else begin
            kind = CYC_READ;
        end

        lane_we = (kind == CYC_WRITE) ? lanes_req : '0;
    end
endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic [LANES-1:0]  lane_we,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rdata_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[addr] <= din[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_q[g*LANE_W +: LANE_W] <= '0;
            end else if (rd_en) begin
                rdata_q[g*LANE_W +: LANE_W] <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/sram_out_ctrl.sv
module sram_out_ctrl
    import sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_t         kind,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic [WORD_W-1:0] rdata_q,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);
    out_state_t state_q;
    out_state_t state_d;

    always_comb begin
        unique case (kind)
            CYC_READ:  state_d = ST_READ;   // take_read
            CYC_WRITE: state_d = ST_WRITE;  // take_write
            default:   state_d = ST_HIZ;    // take_none
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HIZ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_drive = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_READ: begin
                if (!out_en_n && !sleep) begin
                    rd_drive = 1'b1;
                    rd_data  = rdata_q;
                end
            end
            default: begin
                rd_drive = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    // R5
    oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_drive);

    // R7
    sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rd_drive);

    // R6
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_WRITE) |=> !rd_drive);

    // R8
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_NONE) |=> !rd_drive);

    // R9
    data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_hiz_chk: assert (!rd_drive);
        end
    end
endmodule

// File: rtl/sram_bw_core.sv
module sram_bw_core
    import sram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sleep,
    input  logic              wr_all_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);
    cyc_kind_t         kind;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rdata_q;
    logic              rd_en;

    assign rd_en = (kind == CYC_READ);

    sram_wr_decode u_dec (
        .sel_n      (sel_n),
        .sleep      (sleep),
        .wr_all_n   (wr_all_n),
        .byte_wr_n  (byte_wr_n),
        .lane_sel_n (lane_sel_n),
        .kind       (kind),
        .lane_we    (lane_we)
    );

    sram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .lane_we (lane_we),
        .rd_en   (rd_en),
        .rdata_q (rdata_q)
    );

    sram_out_ctrl u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .out_en_n (out_en_n),
        .sleep    (sleep),
        .rdata_q  (rdata_q),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    // R1
    wr_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !sleep && !wr_all_n) |-> (lane_we == '1));

    // R7
    sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0));

    // R4
    read_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_READ) |=> (out_en_n || sleep || rd_drive));
endmodule

// File: tb/sim_sram_bw_core.sv
module sim_sram_bw_core;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    typedef struct {
        logic        drv;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_n, sleep, wr_all_n, byte_wr_n, out_en_n;
    logic [3:0]    lane_sel_n;
    logic [AW-1:0] addr;
    logic [31:0]   din;
    logic [31:0]   rd_data;
    logic          rd_drive;

    logic [31:0] shadow [DEPTH];
    exp_t        scb [$];
    int          n_run  = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    sram_bw_core #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sleep(sleep),
        .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .addr(addr), .din(din),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle, predicts the result after the edge, pushes it
    task automatic cycle(input logic c_sel_n, input logic c_sleep, input logic c_gw,
                         input logic c_bwe, input logic [3:0] c_bw, input logic c_oe,
                         input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        logic        active, wr;
        logic [3:0]  mask;
        exp_t        e;
        @(negedge clk);
        #2;
        sel_n = c_sel_n; sleep = c_sleep; wr_all_n = c_gw; byte_wr_n = c_bwe;
        lane_sel_n = c_bw; out_en_n = c_oe; addr = a; din = d;
        @(posedge clk);
        #1;
        active = !c_sel_n && !c_sleep;
        mask   = !c_gw ? 4'hF : (!c_bwe ? ~c_bw : 4'h0);
        wr     = active && (mask != 4'h0);
        e.tag  = tag;
        if (wr) begin
            for (int i = 0; i < 4; i++)
                if (mask[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
            e.drv = 1'b0; e.data = 32'h0;
        end else if (active && !c_oe) begin
            e.drv = 1'b1; e.data = shadow[a];
        end else begin
            e.drv = 1'b0; e.data = 32'h0;
        end
        scb.push_back(e);
    endtask

    // monitor: pops predictions and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                check({e.tag, " drive"}, {31'h0, rd_drive}, {31'h0, e.drv});
                check({e.tag, " data"}, rd_data, e.data);
            end
        end
    end

    initial begin
        #190000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; sleep = 1'b0; wr_all_n = 1'b1; byte_wr_n = 1'b1;
        lane_sel_n = 4'hF; out_en_n = 1'b0; addr = '0; din = '0;
        #5;
        check("R9 reset drive", {31'h0, rd_drive}, 32'h0);
        check("R9 reset data", rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: override ignores lane controls
        cycle(0, 0, 0, 0, 4'b0101, 0, 8'd5, 32'hA1B2C3D4, "R1 gw write");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd5, 32'h0,        "R1 read back");
        // R2: single lane and mixed lanes
        cycle(0, 0, 1, 0, 4'b1110, 0, 8'd5, 32'h11223344, "R2 lane0 write");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd5, 32'h0,        "R2 lane0 read");
        cycle(0, 0, 1, 0, 4'b0110, 0, 8'd5, 32'h55667788, "R2 lanes 3,0 write");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd5, 32'h0,        "R2 mixed read");
        // R3: qualifier low but no lane selected is a read
        cycle(0, 0, 1, 0, 4'hF,    0, 8'd5, 32'hFFFFFFFF, "R3 empty mask read");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd5, 32'h0,        "R3 unchanged");
        // R5: read with output disabled
        cycle(0, 0, 1, 1, 4'hF,    1, 8'd5, 32'h0,        "R5 oe high read");
        // R7: sleep blocks a write
        cycle(0, 0, 0, 1, 4'hF,    0, 8'd6, 32'h0BADF00D, "R7 setup write");
        cycle(0, 1, 0, 1, 4'hF,    0, 8'd6, 32'hDEADBEEF, "R7 sleep write");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd6, 32'h0,        "R7 read after sleep");
        // R8: deselected write ignored
        cycle(1, 0, 0, 1, 4'hF,    0, 8'd6, 32'h12345678, "R8 desel write");
        cycle(0, 0, 1, 1, 4'hF,    0, 8'd6, 32'h0,        "R8 read after desel");

        // R5 / R7 asynchronous gating while a read is held
        cycle(0, 0, 1, 1, 4'hF, 0, 8'd5, 32'h0, "R4 held read");
        #1 out_en_n = 1'b1;
        #1 check("R5 async oe drop", {31'h0, rd_drive}, 32'h0);
        out_en_n = 1'b0;
        #1 check("R5 async oe return", rd_data, shadow[5]);
        sleep = 1'b1;
        #1 check("R7 async sleep drop", {31'h0, rd_drive}, 32'h0);
        check("R9 data quiet under sleep", rd_data, 32'h0);
        sleep = 1'b0;
        #1 check("R7 async sleep return", {31'h0, rd_drive}, 32'h1);

        // R6 write right after read, R4 read-after-write
        cycle(0, 0, 0, 1, 4'hF, 0, 8'd7, 32'hCAFE0007, "R6 write after read");
        cycle(0, 0, 1, 1, 4'hF, 0, 8'd7, 32'h0,        "R4 read after write");

        // R2 each lane alone
        for (int i = 0; i < 4; i++) begin
            cycle(0, 0, 0, 1, 4'hF, 0, AW'(10 + i), 32'h0, "R2 lane clear");
            cycle(0, 0, 1, 0, ~(4'b1 << i), 0, AW'(10 + i), 32'hFFFFFFFF, "R2 lane set");
            cycle(0, 0, 1, 1, 4'hF, 0, AW'(10 + i), 32'h0, "R2 lane read");
            check("R2 lane position", shadow[10 + i], 32'hFF << (8 * i));
        end

        @(negedge clk);
        #3;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule